// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block gathers interrupt requests from shared peripheral lines, per-CPU private lines and software, keeps per-ID enable, pending, trigger-mode, priority and routing state, and presents each CPU interface with its single best candidate. Software programs it over a simple register bus with an address, write data, a write strobe, a read strobe and a CPU-identity input. The identity input selects which CPU's copy of the banked registers an access touches.

IDs 0 to 15 are software-raised and always edge type. IDs 16 to 31 are private to each CPU and fed by that CPU's own lines: `ppi_lines[c*16 + j]` drives ID 16+j of CPU c. IDs 32 and up are shared: `spi_lines[i]` drives ID 32+i. For every CPU the block registers the winning ID and its priority once per clock. When nothing qualifies, it shows the no-candidate code instead.

Top module: `idist_top`

## Requirements
- R1: Enable words are write-one-to-set at 0x100+4w and write-one-to-clear at 0x180+4w, where word w holds IDs 32w to 32w+31 and bit b is ID 32w+b. Zero bits in a write change nothing. A read of either address returns the current enable bits.
- R2: The enable and pending words for IDs 0 to 31 (word 0) are banked per CPU. An access changes and returns only the copy selected by `bus_cpu`. The pending words are set-pending at 0x200+4w and clear-pending at 0x280+4w, with the same bit layout, and they read back the effective pending state.
- R3: Trigger mode is a 2-bit field per ID at 0xC00+4w, with 16 IDs per word and ID n at bits 2(n mod 16)+1 : 2(n mod 16). The upper bit selects edge (1) or level (0). The lower bit always reads 0.
- R4: The fields for IDs 0 to 15 read as 2'b10 (edge), so word 0 reads 0xAAAAAAAA. Writes to them are ignored.
- R5: Each ID has a target byte at 0x800+4(n/4), in byte n mod 4. Bit k routes the ID to CPU k, and only the low NUM_CPUS bits are stored. For IDs 0 to 31 the byte reads as the accessing CPU's own bit, and writes to it are ignored.
- R6: Each ID has an 8-bit priority byte at 0x400+4(n/4), in byte n mod 4. It reads back as written.
- R7: The read-only type word at 0x004 holds NUM_IDS/32-1 in bits 4:0 and 0 in the other bits.
- R8: Bit 0 of the control word at 0x000 enables forwarding. While it is 0, every CPU shows no candidate from the next clock on.
- R9: An edge-mode ID becomes pending on a 0-to-1 change of its line. It stays pending after the line falls, until a clear-pending write removes it.
- R10: A level-mode ID is pending exactly while its line is high. No stored state remains after the line falls.
- R11: A CPU's candidate must be enabled, pending and targeted at that CPU (IDs 0 to 31 always target their own CPU). The lowest priority value wins, and a tie goes to the lower ID. With no candidate, valid is 0, the ID is 1023 and the priority is 0xFF.
- R12: `bus_rdata` is registered. It shows the addressed word in the cycle after `bus_rd` and holds its value while `bus_rd` is low. Unmapped addresses read 0.
- R13: After reset all enables, pending bits, priorities and shared targets are 0, shared IDs are level mode, forwarding is off and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu | input | 1 | Identity of the accessing CPU |
| bus_rdata | output | 32 | Registered read data |
| spi_lines | input | NUM_IDS-32 | Shared lines, bit i is ID 32+i |
| ppi_lines | input | NUM_CPUS*16 | Private lines, bit c*16+j is ID 16+j of CPU c |
| cand_valid | output | NUM_CPUS | A candidate exists for CPU c |
| cand_id | output | NUM_CPUS*10 | Candidate ID of CPU c at bits 10c+9:10c |
| cand_prio | output | NUM_CPUS*8 | Candidate priority of CPU c at bits 8c+7:8c |

## Verification
Selection is tried with one level line routed to one CPU only, which separates the target check from the enable check. Two lines with equal priority show whether ties go to the lower ID, and lowering the second line's value then shows that priority beats ID order. A single-cycle pulse on an edge-mode line is told apart from a level line by whether the candidate survives the line falling. A software-raised banked ID on one CPU checks that the other CPU neither sees it nor reads its pending bit. Register walks write each field and read it back, including writes that must leave a field unchanged.

// File: rtl/idist_pkg.sv
`timescale 1ns/1ps
// Shared constants and decode for the interrupt distributor.
// Assumes a 12-bit byte address with word-aligned accesses.
package idist_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_CAND_ID = 10'd1023;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_SETEN, SEL_CLREN,
        SEL_SETPD, SEL_CLRPD, SEL_PRIO, SEL_TGT, SEL_CFG
    } reg_sel_e;

    // Map a byte address onto a register region.
    function automatic reg_sel_e decode_addr(input logic [11:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == 12'h000)              s = SEL_CTRL;
        else if (a == 12'h004)         s = SEL_TYPE;
        else if (a[11:7] == 5'b00010)  s = SEL_SETEN;
        else if (a[11:7] == 5'b00011)  s = SEL_CLREN;
        else if (a[11:7] == 5'b00100)  s = SEL_SETPD;
        else if (a[11:7] == 5'b00101)  s = SEL_CLRPD;
        else if (a[11:10] == 2'b01)    s = SEL_PRIO;
        else if (a[11:10] == 2'b10)    s = SEL_TGT;
        else if (a[11:10] == 2'b11)    s = SEL_CFG;
        return s;
    endfunction
endpackage

// File: rtl/idist_capture.sv
`timescale 1ns/1ps
// Rising-edge detector for all incoming interrupt lines.
// Assumes the lines are already synchronous to clk.
module idist_capture #(
    parameter int NUM_SPI  = 32,
    parameter int NUM_PPI  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SPI-1:0] spi_lines,
    input  logic [NUM_PPI-1:0] ppi_lines,
    output logic [NUM_SPI-1:0] spi_rise,
    output logic [NUM_PPI-1:0] ppi_rise
);
    logic [NUM_SPI-1:0] spi_prev;
    logic [NUM_PPI-1:0] ppi_prev;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_prev <= '0;
            ppi_prev <= '0;
        end else begin
            spi_prev <= spi_lines;
            ppi_prev <= ppi_lines;
        end
    end

    // A rise is high now and low last cycle.
    always_comb begin
        spi_rise = spi_lines & ~spi_prev;
        ppi_rise = ppi_lines & ~ppi_prev;
    end
endmodule

// File: rtl/idist_regs.sv
`timescale 1ns/1ps
// Register bank: enables, pending, trigger mode, priority, targets,
// global control and read-back. Produces per-CPU armed vectors.
// Assumes NUM_IDS is a multiple of 32 and at least 64.
module idist_regs
    import idist_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    localparam int NSPI    = NUM_IDS - 32,
    localparam int NW      = NUM_IDS / 32,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [11:0]                       bus_addr,
    input  logic [31:0]                       bus_wdata,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [CPU_W-1:0]                  bus_cpu,
    output logic [31:0]                       bus_rdata,
    input  logic [NSPI-1:0]                   spi_lines,
    input  logic [NUM_CPUS*16-1:0]            ppi_lines,
    input  logic [NSPI-1:0]                   spi_rise,
    input  logic [NUM_CPUS*16-1:0]            ppi_rise,
    output logic                              dist_on,
    output logic [NUM_CPUS-1:0][NUM_IDS-1:0]  armed,
    output logic [NUM_IDS-1:0][7:0]           prio
);
    reg_sel_e                          sel;
    logic [4:0]                        wsmall;
    logic [7:0]                        wlarge;
    logic                              ctrl_q;
    logic [NUM_CPUS-1:0][31:0]         en_bank;
    logic [NUM_CPUS-1:0][31:0]         pd_bank;
    logic [NSPI-1:0]                   en_spi;
    logic [NSPI-1:0]                   pd_spi;
    logic [NUM_IDS-1:0]                edge_q;
    logic [NUM_IDS-1:0][7:0]           prio_q;
    logic [NUM_IDS-1:0][NUM_CPUS-1:0]  tgt_q;
    logic [NUM_CPUS-1:0][31:0]         pe_bank;
    logic [NSPI-1:0]                   pe_spi;
    logic [31:0]                       rd_val;

    assign sel     = decode_addr(bus_addr);
    assign wsmall  = bus_addr[6:2];
    assign wlarge  = bus_addr[9:2];
    assign dist_on = ctrl_q;
    assign prio    = prio_q;

    // Apply line captures and bus writes to the stored state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 1'b0;
            en_bank <= '0;
            pd_bank <= '0;
            en_spi  <= '0;
            pd_spi  <= '0;
            edge_q  <= {{(NUM_IDS-16){1'b0}}, 16'hFFFF};
            prio_q  <= '0;
            tgt_q   <= '0;
        end else begin
            for (int c = 0; c < NUM_CPUS; c++)
                for (int j = 0; j < 16; j++)
                    if (ppi_rise[c*16+j] && edge_q[16+j]) pd_bank[c][16+j] <= 1'b1;
            for (int i = 0; i < NSPI; i++)
                if (spi_rise[i] && edge_q[32+i]) pd_spi[i] <= 1'b1;
            if (bus_wr) begin
                unique case (sel)
                    SEL_CTRL: ctrl_q <= bus_wdata[0];
                    SEL_SETEN, SEL_CLREN, SEL_SETPD, SEL_CLRPD: begin
                        for (int b = 0; b < 32; b++) begin
                            if (bus_wdata[b] && wsmall == 5'd0) begin
                                if (sel == SEL_SETEN) en_bank[bus_cpu][b] <= 1'b1;
                                if (sel == SEL_CLREN) en_bank[bus_cpu][b] <= 1'b0;
                                if (sel == SEL_SETPD) pd_bank[bus_cpu][b] <= 1'b1;
                                if (sel == SEL_CLRPD) pd_bank[bus_cpu][b] <= 1'b0;
                            end
                            for (int w = 1; w < NW; w++) begin
                                if (bus_wdata[b] && wsmall == 5'(w)) begin
                                    if (sel == SEL_SETEN) en_spi[(w-1)*32+b] <= 1'b1;
                                    if (sel == SEL_CLREN) en_spi[(w-1)*32+b] <= 1'b0;
                                    if (sel == SEL_SETPD) pd_spi[(w-1)*32+b] <= 1'b1;
                                    if (sel == SEL_CLRPD) pd_spi[(w-1)*32+b] <= 1'b0;
                                end
                            end
                        end
                    end
                    SEL_PRIO: begin
                        for (int n = 0; n < NUM_IDS; n++)
                            if (wlarge == 8'(n/4)) prio_q[n] <= bus_wdata[8*(n%4) +: 8];
                    end
                    SEL_TGT: begin
                        for (int n = 32; n < NUM_IDS; n++)
                            if (wlarge == 8'(n/4)) tgt_q[n] <= bus_wdata[8*(n%4) +: NUM_CPUS];
                    end
                    SEL_CFG: begin
                        for (int n = 16; n < NUM_IDS; n++)
                            if (wlarge == 8'(n/16)) edge_q[n] <= bus_wdata[2*(n%16)+1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Effective pending: stored bits plus level-mode lines that are high.
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int j = 0; j < 16; j++)
                pe_bank[c][j] = pd_bank[c][j];
            for (int j = 0; j < 16; j++)
                pe_bank[c][16+j] = pd_bank[c][16+j] | (~edge_q[16+j] & ppi_lines[c*16+j]);
        end
        for (int i = 0; i < NSPI; i++)
            pe_spi[i] = pd_spi[i] | (~edge_q[32+i] & spi_lines[i]);
    end

    // Qualify each ID per CPU by control, enable, pending and target.
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int i = 0; i < 32; i++)
                armed[c][i] = ctrl_q & en_bank[c][i] & pe_bank[c][i];
            for (int i = 0; i < NSPI; i++)
                armed[c][32+i] = ctrl_q & en_spi[i] & pe_spi[i] & tgt_q[32+i][c];
        end
    end

    // Assemble the word addressed by the current read.
    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_CTRL: rd_val = {31'd0, ctrl_q};
            SEL_TYPE: rd_val = {27'd0, 5'(NW-1)};
            SEL_SETEN, SEL_CLREN, SEL_SETPD, SEL_CLRPD: begin
                if (wsmall == 5'd0)
                    rd_val = (sel == SEL_SETEN || sel == SEL_CLREN) ? en_bank[bus_cpu] : pe_bank[bus_cpu];
                for (int w = 1; w < NW; w++)
                    if (wsmall == 5'(w))
                        rd_val = (sel == SEL_SETEN || sel == SEL_CLREN) ?
                                 en_spi[(w-1)*32 +: 32] : pe_spi[(w-1)*32 +: 32];
            end
            SEL_PRIO: begin
                for (int n = 0; n < NUM_IDS; n++)
                    if (wlarge == 8'(n/4)) rd_val[8*(n%4) +: 8] = prio_q[n];
            end
            SEL_TGT: begin
                for (int n = 0; n < 32; n++)
                    if (wlarge == 8'(n/4)) rd_val[8*(n%4) +: 8] = 8'(1) << bus_cpu;
                for (int n = 32; n < NUM_IDS; n++)
                    if (wlarge == 8'(n/4)) rd_val[8*(n%4) +: 8] = 8'(tgt_q[n]);
            end
            SEL_CFG: begin
                for (int n = 0; n < NUM_IDS; n++)
                    if (wlarge == 8'(n/16)) rd_val[2*(n%16) +: 2] = {edge_q[n], 1'b0};
            end
            default: rd_val = '0;
        endcase
    end

    // Register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/idist_arb.sv
`timescale 1ns/1ps
// Per-CPU selector: lowest priority value among armed IDs, ties to
// the lower ID. Output is registered; no candidate gives ID 1023, 0xFF.
module idist_arb
    import idist_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IDS-1:0]       armed,
    input  logic [NUM_IDS-1:0][7:0]  prio,
    output logic                     cand_valid,
    output logic [ID_W-1:0]          cand_id,
    output logic [7:0]               cand_prio
);
    logic            found;
    logic [ID_W-1:0] best_id;
    logic [7:0]      best_p;

    // Ascending scan; only a strictly lower value replaces the holder.
    always_comb begin
        found   = 1'b0;
        best_id = NO_CAND_ID;
        best_p  = 8'hFF;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (armed[i] && (!found || prio[i] < best_p)) begin
                found   = 1'b1;
                best_id = ID_W'(i);
                best_p  = prio[i];
            end
        end
    end

    // Register the winner for the CPU interface.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_valid <= 1'b0;
            cand_id    <= NO_CAND_ID;
            cand_prio  <= 8'hFF;
        end else begin
            cand_valid <= found;
            cand_id    <= best_id;
            cand_prio  <= best_p;
        end
    end
endmodule

// File: rtl/idist_top.sv
`timescale 1ns/1ps
// Interrupt distributor top: edge capture, register bank and one
// selector per CPU. Assumes NUM_IDS multiple of 32, at least 64.
module idist_top
    import idist_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [11:0]               bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [CPU_W-1:0]          bus_cpu,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_IDS-33:0]       spi_lines,
    input  logic [NUM_CPUS*16-1:0]    ppi_lines,
    output logic [NUM_CPUS-1:0]       cand_valid,
    output logic [NUM_CPUS*ID_W-1:0]  cand_id,
    output logic [NUM_CPUS*8-1:0]     cand_prio
);
    logic [NUM_IDS-33:0]              spi_rise;
    logic [NUM_CPUS*16-1:0]           ppi_rise;
    logic                             dist_on;
    logic [NUM_CPUS-1:0][NUM_IDS-1:0] armed;
    logic [NUM_IDS-1:0][7:0]          prio;

    idist_capture #(.NUM_SPI(NUM_IDS-32), .NUM_PPI(NUM_CPUS*16)) u_cap (
        .clk(clk), .rst_n(rst_n), .spi_lines(spi_lines), .ppi_lines(ppi_lines),
        .spi_rise(spi_rise), .ppi_rise(ppi_rise)
    );

    idist_regs #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
        .spi_lines(spi_lines), .ppi_lines(ppi_lines), .spi_rise(spi_rise),
        .ppi_rise(ppi_rise), .dist_on(dist_on), .armed(armed), .prio(prio)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        idist_arb #(.NUM_IDS(NUM_IDS)) u_arb (
            .clk(clk), .rst_n(rst_n), .armed(armed[c]), .prio(prio),
            .cand_valid(cand_valid[c]), .cand_id(cand_id[c*ID_W +: ID_W]),
            .cand_prio(cand_prio[c*8 +: 8])
        );
    end
endmodule

// File: rtl/idist_chk.sv
`timescale 1ns/1ps
// Property checker for idist_top, attached by bind below.
module idist_chk #(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [11:0]            bus_addr,
    input logic                   bus_rd,
    input logic [31:0]            bus_rdata,
    input logic                   dist_on,
    input logic [NUM_CPUS-1:0]    cand_valid,
    input logic [NUM_CPUS*10-1:0] cand_id
);
    p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_on |=> (cand_valid == '0));

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_type_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'h004) |=> (bus_rdata == 32'(NUM_IDS/32 - 1)));

    p_sgi_mode_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'hC00) |=> (bus_rdata == 32'hAAAA_AAAA));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
        p_id_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cand_valid[c] |-> (cand_id[c*10 +: 10] < 10'(NUM_IDS)));
    end
endmodule

bind idist_top idist_chk #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .dist_on(dist_on), .cand_valid(cand_valid),
    .cand_id(cand_id)
);

// File: tb/sim_idist_top.sv
`timescale 1ns/1ps
module sim_idist_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic [31:0] bus_rdata;
    logic [31:0] spi_lines = '0;
    logic [31:0] ppi_lines = '0;
    logic [1:0]  cand_valid;
    logic [19:0] cand_id;
    logic [15:0] cand_prio;
    int checks = 0;
    int errors = 0;
    logic [31:0] q;

    always #10 clk = ~clk;

    idist_top u0 (.*);

    // Vector: {write, cpu, addr, data, expected read, requirement number}
    localparam int NV = 30;
    localparam logic [81:0] VEC [NV] = '{
        {1'b0,1'b0,12'h004,32'h0,32'h00000001,4'd7},        // R7
        {1'b0,1'b0,12'hC00,32'h0,32'hAAAAAAAA,4'd4},        // R4
        {1'b1,1'b0,12'hC00,32'h0,32'h0,4'd4},
        {1'b0,1'b0,12'hC00,32'h0,32'hAAAAAAAA,4'd4},
        {1'b1,1'b0,12'hC04,32'hFFFFFFFF,32'h0,4'd3},
        {1'b0,1'b0,12'hC04,32'h0,32'hAAAAAAAA,4'd3},        // R3
        {1'b1,1'b0,12'hC04,32'h0,32'h0,4'd3},
        {1'b0,1'b0,12'hC04,32'h0,32'h0,4'd3},
        {1'b1,1'b0,12'h104,32'h5,32'h0,4'd1},
        {1'b0,1'b0,12'h104,32'h0,32'h5,4'd1},               // R1
        {1'b0,1'b0,12'h184,32'h0,32'h5,4'd1},
        {1'b1,1'b0,12'h184,32'h1,32'h0,4'd1},
        {1'b0,1'b0,12'h104,32'h0,32'h4,4'd1},
        {1'b1,1'b0,12'h104,32'h0,32'h0,4'd1},
        {1'b0,1'b1,12'h104,32'h0,32'h4,4'd1},
        {1'b1,1'b0,12'h100,32'h00010003,32'h0,4'd2},
        {1'b0,1'b1,12'h100,32'h0,32'h0,4'd2},               // R2
        {1'b0,1'b0,12'h180,32'h0,32'h00010003,4'd2},
        {1'b1,1'b0,12'h408,32'h11223344,32'h0,4'd6},
        {1'b0,1'b1,12'h408,32'h0,32'h11223344,4'd6},        // R6
        {1'b1,1'b0,12'h820,32'hFF020301,32'h0,4'd5},
        {1'b0,1'b0,12'h820,32'h0,32'h03020301,4'd5},        // R5
        {1'b0,1'b1,12'h800,32'h0,32'h02020202,4'd5},
        {1'b1,1'b0,12'h800,32'h0,32'h0,4'd5},
        {1'b0,1'b0,12'h800,32'h0,32'h01010101,4'd5},
        {1'b1,1'b0,12'h184,32'hFFFFFFFF,32'h0,4'd1},
        {1'b1,1'b0,12'h180,32'hFFFFFFFF,32'h0,4'd1},
        {1'b0,1'b0,12'h100,32'h0,32'h0,4'd1},
        {1'b1,1'b0,12'h000,32'h1,32'h0,4'd8},
        {1'b0,1'b0,12'h000,32'h0,32'h1,4'd8}                // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic c, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Compare one CPU's candidate; valid 0 implies ID 1023, priority FF.
    task automatic cand(input string req, input int c, input logic v, input int id, input logic [7:0] p);
        check(req, {31'd0, cand_valid[c]}, {31'd0, v});
        check(req, {22'd0, cand_id[c*10 +: 10]}, v ? 32'(id) : 32'd1023);
        check(req, {24'd0, cand_prio[c*8 +: 8]}, v ? {24'd0, p} : 32'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        cand("R13", 0, 1'b0, 0, 8'h0);
        cand("R13", 1, 1'b0, 0, 8'h0);
        check("R13", bus_rdata, 32'h0);
        rd(1'b0, 12'h000, q); check("R13", q, 32'h0);
        rd(1'b0, 12'h404, q); check("R13", q, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][81]) wr(VEC[v][80], VEC[v][79:68], VEC[v][67:36]);
            else begin
                rd(VEC[v][80], VEC[v][79:68], q);
                check($sformatf("R%0d", VEC[v][3:0]), q, VEC[v][35:4]);
            end
        end

        // R11: level lines 40 (CPU0 only) and 41 (both CPUs), equal priority
        wr(1'b0, 12'h428, 32'h00002020);
        wr(1'b0, 12'h828, 32'h00000301);
        wr(1'b0, 12'h104, 32'h00000300);
        spi_lines[8] = 1'b1; settle();
        cand("R11", 0, 1'b1, 40, 8'h20);
        cand("R11", 1, 1'b0, 0, 8'h0);
        spi_lines[9] = 1'b1; settle();
        cand("R11", 0, 1'b1, 40, 8'h20);
        cand("R11", 1, 1'b1, 41, 8'h20);
        wr(1'b0, 12'h428, 32'h00001020); settle();
        cand("R11", 0, 1'b1, 41, 8'h10);
        // R8: forwarding off hides all candidates
        wr(1'b0, 12'h000, 32'h0); settle();
        cand("R8", 0, 1'b0, 0, 8'h0);
        cand("R8", 1, 1'b0, 0, 8'h0);
        wr(1'b0, 12'h000, 32'h1); settle();
        cand("R8", 0, 1'b1, 41, 8'h10);
        // R10: level lines drop, nothing remains
        spi_lines[9:8] = 2'b00; settle();
        cand("R10", 0, 1'b0, 0, 8'h0);
        cand("R10", 1, 1'b0, 0, 8'h0);

        // R9: edge-mode ID 44 routed to CPU1, one-cycle pulse
        wr(1'b0, 12'hC08, 32'h02000000);
        wr(1'b0, 12'h82C, 32'h00000002);
        wr(1'b0, 12'h104, 32'h00001000);
        @(negedge clk); spi_lines[12] = 1'b1;
        @(negedge clk); spi_lines[12] = 1'b0;
        settle();
        cand("R9", 1, 1'b1, 44, 8'h00);
        cand("R9", 0, 1'b0, 0, 8'h0);
        rd(1'b1, 12'h204, q); check("R9", q, 32'h00001000);
        wr(1'b1, 12'h284, 32'h00001000); settle();
        cand("R9", 1, 1'b0, 0, 8'h0);

        // R2: software-raised banked ID 3 on CPU1 only
        wr(1'b1, 12'h100, 32'h00000008);
        wr(1'b1, 12'h200, 32'h00000008); settle();
        cand("R2", 1, 1'b1, 3, 8'h00);
        cand("R2", 0, 1'b0, 0, 8'h0);
        rd(1'b0, 12'h200, q); check("R2", q, 32'h0);

        // R12: read data holds while the strobe is low
        rd(1'b1, 12'h200, q); check("R12", q, 32'h00000008);
        @(negedge clk); bus_addr = 12'h004;
        repeat (2) @(negedge clk);
        check("R12", bus_rdata, 32'h00000008);
        rd(1'b0, 12'h0F0, q); check("R12", q, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule